// File: doc/BRIEF.md
# Two-Wire Control Register Slave

This block is a slave on a two-wire serial control bus. It takes write frames made of a device address, a function byte and a data byte, and it loads the data into one of a few control latches. The latches hold the audio matrix selection, a mute flag, a test flag, a free-run frequency trim and a separation trim. A read frame returns one status byte that reports the incoming identification state (stereo or bilingual) as a bit pair followed by its complement, so the host can catch a corrupted transfer.

A strap input moves the device address, which lets two of these slaves share one bus. SCL and SDA are synchronized to the system clock and edge-detected there, so the system clock must run well above the bus bit rate. SDA is open-drain. The block only ever asks for the line to be pulled low, and the pad or bus model does the wired-AND.

Top module: `ctl_twowire_slave`

## Requirements
- R1: The 7-bit device address is 42h with `strap_gnd_i`=0 and 43h with `strap_gnd_i`=1. The write and read address bytes are therefore 84h/85h and 86h/87h. The slave acknowledges an address byte only when its upper seven bits match. Otherwise it does not drive SDA and changes no latch.
- R2: A falling SDA while SCL is high is a start, and it restarts address reception from any state. A rising SDA while SCL is high is a stop, and it returns the slave to idle. Both conditions release SDA. A frame cut short by a start writes nothing.
- R3: A write frame is made of the address byte, the function byte and the data byte, each sent MSB first. The slave pulls SDA low during the ninth clock after each of these bytes.
- R4: Bits 7:5 of the function byte select the target latch, and bits 4:0 are don't-care. 000 loads the matrix mode from data[7:6] (00 mono, 01 stereo, 10 bilingual, 11 sub). 001 loads mute from data[7]. 010 loads test from data[7]. 011 loads frequency trim from data[7:6]. 100 loads separation trim from data[7:3]. All other data bits are ignored.
- R5: Function codes 101, 110 and 111 are still acknowledged after a matching address, but they change no latch.
- R6: After reset, mode, mute, test and frequency trim are 0, the separation trim is 10000b, and SDA is released.
- R7: In a read frame the slave acknowledges the second byte and ignores it. It then drives the status byte in the third byte, MSB first: bit7 = bilingual, bit6 = stereo, bit5 = not bilingual, bit4 = not stereo, bits 3:0 = 0. So mono reads 30h, bilingual reads 90h and stereo reads 60h.
- R8: During a read the slave releases SDA in the host's acknowledge slot. If the host acknowledges, the status byte is sent again. On a not-acknowledge the slave goes idle and stays released.
- R9: The slave's SDA drive only ever pulls low, and it is only switched on while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND result) |
| sda_drive_low_o | output | 1 | 1 = pull SDA low, 0 = release |
| strap_gnd_i | input | 1 | Address strap, 1 selects 86h/87h |
| id_stereo_i | input | 1 | Stereo identification detected |
| id_bilingual_i | input | 1 | Bilingual identification detected |
| mode_o | output | 2 | Matrix mode latch |
| mute_o | output | 1 | Mute latch |
| test_o | output | 1 | Test latch |
| freq_o | output | 2 | Free-run frequency trim latch |
| sep_o | output | 5 | Separation trim latch |

## Verification
The assertions assume that the bus master changes SDA only while SCL is low, except when it forms a start or a stop. They also assume that each SCL level lasts longer than the synchronizer delay, so every edge is seen once and in order. The bench drives SCL with each level lasting eight system clocks and moves SDA a quarter bit after SCL falls. It samples SDA in the middle of the high phase. Every SDA edge made while SCL is high is therefore a deliberate start or stop.

// File: rtl/tw_ctrl_pkg.sv
package tw_ctrl_pkg;
  localparam int SEP_W  = 5;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_ACK_A, S_SUB, S_ACK_S, S_WDATA, S_ACK_W, S_TX, S_MACK
  } tw_state_e;

  localparam logic [2:0] FN_MODE = 3'd0;
  localparam logic [2:0] FN_MUTE = 3'd1;
  localparam logic [2:0] FN_TEST = 3'd2;
  localparam logic [2:0] FN_FREQ = 3'd3;
  localparam logic [2:0] FN_SEP  = 3'd4;

  typedef struct packed {
    logic [1:0]       mode;
    logic             mute;
    logic             test;
    logic [1:0]       freq;
    logic [SEP_W-1:0] sep;
  } ctrl_regs_t;
endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_q  <= scl_sh[STAGES-1];
      sda_q  <= sda_sh[STAGES-1];
    end
  end

  assign scl_o      = scl_sh[STAGES-1];
  assign sda_o      = sda_sh[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  // SDA edges while SCL stays high
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/tw_frame_fsm.sv
module tw_frame_fsm
  import tw_ctrl_pkg::*;
#(
  parameter int KEEP_W = SEP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [6:0]        dev_addr_i,
  input  logic [BYTE_W-1:0] status_i,
  output logic              sda_low_o,
  output logic              wr_en_o,
  output logic [2:0]        wr_fn_o,
  output logic [KEEP_W-1:0] wr_data_o
);
  localparam int CW = $clog2(BYTE_W + 1);
  localparam logic [CW-1:0] LAST = CW'(BYTE_W);

  tw_state_e         state;
  logic [CW-1:0]     cnt;
  logic [BYTE_W-1:0] sh, tx;
  logic [2:0]        fn_q;
  logic              rw, mack;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state     <= S_IDLE;
      cnt       <= '0;
      sh        <= '0;
      tx        <= '0;
      fn_q      <= '0;
      rw        <= 1'b0;
      mack      <= 1'b0;
      sda_low_o <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_fn_o   <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (start_i) begin
        state     <= S_ADDR;
        cnt       <= '0;
        sda_low_o <= 1'b0;
      end else if (stop_i) begin
        state     <= S_IDLE;
        sda_low_o <= 1'b0;
      end else begin
        unique case (state)
          S_ADDR, S_SUB, S_WDATA: begin
            if (scl_rise_i && cnt != LAST) begin
              sh  <= {sh[BYTE_W-2:0], sda_i};
              cnt <= cnt + CW'(1);
            end else if (scl_fall_i && cnt == LAST) begin
              if (state == S_ADDR) begin
                if (sh[7:1] == dev_addr_i) begin
                  sda_low_o <= 1'b1;
                  rw        <= sh[0];
                  state     <= S_ACK_A;
                end else begin
                  state <= S_IDLE;
                end
              end else if (state == S_SUB) begin
                fn_q      <= sh[7:5];
                sda_low_o <= 1'b1;
                state     <= S_ACK_S;
              end else begin
                sda_low_o <= 1'b1;
                wr_en_o   <= 1'b1;
                wr_fn_o   <= fn_q;
                wr_data_o <= sh[BYTE_W-1 -: KEEP_W];
                state     <= S_ACK_W;
              end
            end
          end
          S_ACK_A: if (scl_fall_i) begin
            sda_low_o <= 1'b0;
            cnt       <= '0;
            state     <= S_SUB;
          end
          S_ACK_S: if (scl_fall_i) begin
            if (rw) begin
              tx        <= status_i;
              sda_low_o <= ~status_i[BYTE_W-1];
              cnt       <= CW'(1);
              state     <= S_TX;
            end else begin
              sda_low_o <= 1'b0;
              cnt       <= '0;
              state     <= S_WDATA;
            end
          end
          S_ACK_W: if (scl_fall_i) begin
            sda_low_o <= 1'b0;
            state     <= S_IDLE;
          end
          S_TX: if (scl_fall_i) begin
            if (cnt == LAST) begin
              sda_low_o <= 1'b0;
              state     <= S_MACK;
            end else begin
              tx        <= tx << 1;
              sda_low_o <= ~tx[BYTE_W-2];
              cnt       <= cnt + CW'(1);
            end
          end
          S_MACK: begin
            if (scl_rise_i) mack <= ~sda_i;
            else if (scl_fall_i) begin
              if (mack) begin
                tx        <= status_i;
                sda_low_o <= ~status_i[BYTE_W-1];
                cnt       <= CW'(1);
                state     <= S_TX;
              end else begin
                state <= S_IDLE;
              end
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/tw_ctrl_regs.sv
module tw_ctrl_regs
  import tw_ctrl_pkg::*;
#(
  parameter int               KEEP_W  = SEP_W,
  parameter logic [SEP_W-1:0] SEP_RST = SEP_W'(1) << (SEP_W - 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_fn_i,
  input  logic [KEEP_W-1:0] wr_data_i,
  output ctrl_regs_t        regs_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regs_o      <= '0;
      regs_o.sep  <= SEP_RST;
    end else if (wr_en_i) begin
      unique case (wr_fn_i)
        FN_MODE: regs_o.mode <= wr_data_i[KEEP_W-1 -: 2];
        FN_MUTE: regs_o.mute <= wr_data_i[KEEP_W-1];
        FN_TEST: regs_o.test <= wr_data_i[KEEP_W-1];
        FN_FREQ: regs_o.freq <= wr_data_i[KEEP_W-1 -: 2];
        FN_SEP:  regs_o.sep  <= wr_data_i[KEEP_W-1 -: SEP_W];
        default: ; // unused codes: acked, no effect
      endcase
    end
  end
endmodule

// File: rtl/tw_id_status.sv
module tw_id_status
  import tw_ctrl_pkg::*;
(
  input  logic              stereo_i,
  input  logic              bilingual_i,
  output logic [BYTE_W-1:0] status_o
);
  // true pair then complement pair, low nibble zero
  assign status_o = {bilingual_i, stereo_i, ~bilingual_i, ~stereo_i, {(BYTE_W-4){1'b0}}};
endmodule

// File: rtl/ctl_twowire_slave.sv
module ctl_twowire_slave
  import tw_ctrl_pkg::*;
#(
  parameter logic [6:0] ADDR_OPEN   = 7'h42,
  parameter logic [6:0] ADDR_GND    = 7'h43,
  parameter int         SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_drive_low_o,
  input  logic             strap_gnd_i,
  input  logic             id_stereo_i,
  input  logic             id_bilingual_i,
  output logic [1:0]       mode_o,
  output logic             mute_o,
  output logic             test_o,
  output logic [1:0]       freq_o,
  output logic [SEP_W-1:0] sep_o
);
  localparam int RW = $bits(ctrl_regs_t);

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic wr_en;
  logic [2:0] wr_fn;
  logic [SEP_W-1:0] wr_data;
  logic [BYTE_W-1:0] status;
  logic [6:0] dev_addr;
  ctrl_regs_t regs;
  logic [RW-1:0] regs_vec;

  assign dev_addr = strap_gnd_i ? ADDR_GND : ADDR_OPEN;

  tw_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_i(sda_i),
    .scl_o(scl_lvl), .sda_o(sda_lvl), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  tw_id_status u_status (
    .stereo_i(id_stereo_i), .bilingual_i(id_bilingual_i), .status_o(status)
  );

  tw_frame_fsm #(.KEEP_W(SEP_W)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .sda_i(sda_lvl), .start_i(start_det), .stop_i(stop_det), .dev_addr_i(dev_addr),
    .status_i(status), .sda_low_o(sda_drive_low_o), .wr_en_o(wr_en),
    .wr_fn_o(wr_fn), .wr_data_o(wr_data)
  );

  tw_ctrl_regs #(.KEEP_W(SEP_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_fn_i(wr_fn),
    .wr_data_i(wr_data), .regs_o(regs)
  );

  assign regs_vec = regs;
  assign mode_o   = regs.mode;
  assign mute_o   = regs.mute;
  assign test_o   = regs.test;
  assign freq_o   = regs.freq;
  assign sep_o    = regs.sep;
endmodule

// File: rtl/tw_ctrl_checker.sv
module tw_ctrl_checker #(
  parameter int RW = 11
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          scl_lvl,
  input logic          start_det,
  input logic          stop_det,
  input logic          sda_drive_low_o,
  input logic          wr_en,
  input logic [2:0]    wr_fn,
  input logic [RW-1:0] regs_vec
);
  AST_PULL_ONLY_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_drive_low_o) |-> !scl_lvl); // R9
  AST_STOP_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !sda_drive_low_o); // R2
  AST_START_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> !sda_drive_low_o); // R2
  AST_BAD_FN_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && wr_fn > 3'd4) |=> $stable(regs_vec)); // R5
  AST_LATCH_ONLY_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en |=> $stable(regs_vec)); // R4
  AST_WRITE_WITH_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |=> sda_drive_low_o || start_det || stop_det); // R3
endmodule

bind ctl_twowire_slave tw_ctrl_checker #(.RW(RW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_lvl(scl_lvl), .start_det(start_det),
  .stop_det(stop_det), .sda_drive_low_o(sda_drive_low_o), .wr_en(wr_en),
  .wr_fn(wr_fn), .regs_vec(regs_vec)
);

// File: tb/ctl_twowire_slave_bench.sv
module ctl_twowire_slave_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1, strap = 1'b0, st = 1'b0, bi = 1'b0;
  logic drv, mute, test;
  logic [1:0] mode, freq;
  logic [4:0] sep;
  wire sda_bus = sda_m & ~drv;

  always #10 clk = ~clk;

  ctl_twowire_slave u_ctl_twowire_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_drive_low_o(drv), .strap_gnd_i(strap), .id_stereo_i(st),
    .id_bilingual_i(bi), .mode_o(mode), .mute_o(mute), .test_o(test),
    .freq_o(freq), .sep_o(sep)
  );

  int total = 0, bad = 0;
  localparam int Q = 4;
  logic [1:0] e_mode = 0, e_freq = 0;
  logic e_mute = 0, e_test = 0;
  logic [4:0] e_sep = 5'b10000;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic bit_io(input logic b, output logic r);
    sda_m = b; wq(); scl = 1'b1; wq(); r = sda_bus; wq(); scl = 1'b0; wq();
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq(); wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_io(b[i], r);
    bit_io(1'b1, r);
    ack = !r;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] v);
    logic r;
    for (int i = 7; i >= 0; i--) begin bit_io(1'b1, r); v[i] = r; end
    bit_io(!mack, r);
  endtask

  task automatic wr_frame(input logic [7:0] a, input logic [7:0] s, input logic [7:0] d,
                          output logic a0, output logic a1, output logic a2);
    a1 = 0; a2 = 0;
    bus_start();
    send_byte(a, a0);
    if (a0) begin send_byte(s, a1); send_byte(d, a2); end
    bus_stop();
  endtask

  task automatic apply(input logic [7:0] s, input logic [7:0] d);
    case (s[7:5])
      3'd0: e_mode = d[7:6];
      3'd1: e_mute = d[7];
      3'd2: e_test = d[7];
      3'd3: e_freq = d[7:6];
      3'd4: e_sep  = d[7:3];
      default: ;
    endcase
  endtask

  task automatic check_regs(input string tag);
    chk({tag, " mode"}, mode, e_mode);
    chk({tag, " mute"}, mute, e_mute);
    chk({tag, " test"}, test, e_test);
    chk({tag, " freq"}, freq, e_freq);
    chk({tag, " sep"},  sep,  e_sep);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_regs("R6 reset");
    chk("R6 sda released", drv, 0);

    // R1: address sweep around both device addresses, both straps
    for (int s = 0; s < 2; s++) begin
      strap = s[0];
      for (int a = 'h3c; a <= 'h47; a++) begin
        logic ack;
        bus_start();
        send_byte({a[6:0], 1'b0}, ack);
        bus_stop();
        chk("R1 addr ack", ack, (a == (s == 0 ? 'h42 : 'h43)) ? 1 : 0);
      end
      check_regs("R1 no change");
    end
    strap = 1'b0;

    // R3/R4: every value of every function, noise in don't-care bits
    for (int fn = 0; fn < 5; fn++) begin
      int w = (fn == 4) ? 5 : ((fn == 0 || fn == 3) ? 2 : 1);
      for (int v = 0; v < (1 << w); v++) begin
        logic a0, a1, a2;
        logic [7:0] s = {fn[2:0], 5'(v * 7 + 3)};
        logic [7:0] d = 8'((v << (8 - w)) | (8'h55 & ((1 << (8 - w)) - 1)));
        wr_frame(8'h84, s, d, a0, a1, a2);
        chk("R3 ack", {a0, a1, a2}, 3'b111);
        apply(s, d);
        check_regs("R4");
        chk("R9 idle release", drv, 0);
      end
    end

    // R5: unused function codes acked, no effect
    for (int fn = 5; fn < 8; fn++) begin
      for (int k = 0; k < 2; k++) begin
        logic a0, a1, a2;
        wr_frame(8'h84, {fn[2:0], 5'h1f}, k ? 8'hff : 8'h00, a0, a1, a2);
        chk("R5 ack", {a0, a1, a2}, 3'b111);
        check_regs("R5");
      end
    end

    // R1: other strap address ignored
    begin
      logic a0, a1, a2;
      wr_frame(8'h86, 8'h20, {~e_mute, 7'h0}, a0, a1, a2);
      chk("R1 foreign ack", a0, 0);
      check_regs("R1 foreign");
    end

    // R7/R8: status read for each id combination
    for (int id = 0; id < 4; id++) begin
      logic a0, a1;
      logic [7:0] v1, v2;
      logic eb, es;
      es = id[0]; eb = id[1];
      st = es; bi = eb;
      bus_start();
      send_byte(8'h85, a0);
      send_byte(8'h9f, a1);
      recv_byte(1'b1, v1);
      recv_byte(1'b0, v2);
      chk("R8 released after nack", drv, 0);
      bus_stop();
      chk("R7 read acks", {a0, a1}, 2'b11);
      chk("R7 status", v1, {eb, es, ~eb, ~es, 4'h0});
      chk("R8 repeat", v2, {eb, es, ~eb, ~es, 4'h0});
      check_regs("R7 sub ignored");
    end

    // R2: frame cut by start, then full frame
    begin
      logic a, r;
      bus_start();
      send_byte(8'h84, a);
      send_byte(8'h20, a);
      for (int i = 0; i < 3; i++) bit_io(~e_mute, r);
      bus_start();
      send_byte(8'h84, a);
      send_byte(8'h80, a);
      send_byte(8'h28, a);
      bus_stop();
      chk("R2 restart ack", a, 1);
      apply(8'h80, 8'h28);
      check_regs("R2 restart");
    end

    // R1: strapped to ground
    strap = 1'b1;
    begin
      logic a0, a1, a2;
      logic [7:0] v;
      wr_frame(8'h86, 8'h1f, 8'hc0, a0, a1, a2);
      chk("R1 strap write", {a0, a1, a2}, 3'b111);
      apply(8'h1f, 8'hc0);
      check_regs("R1 strap");
      st = 1'b1; bi = 1'b0;
      bus_start();
      send_byte(8'h87, a0);
      send_byte(8'h00, a1);
      recv_byte(1'b0, v);
      bus_stop();
      chk("R7 strap read", v, 8'h60);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=%0h exp=%0h", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule